// File: doc/BRIEF.md
# Core-to-bus clock ratio enable generator

The block turns a 4-bit configuration code into a fixed relationship between a core clock and a bus clock. It expresses that relationship as single-cycle enable pulses on one fast reference clock that runs at twice the core rate. A core enable fires on every second reference tick. A bus enable fires once per bus period, and that period is measured in reference ticks. Each tick is half a core cycle, so half-integer ratios need no second clock edge.

The code is captured only while reset is held and on the first reference edge after reset is released. From then on it is frozen until the next reset. One code selects bypass, where the core follows the bus one-to-one. Another code selects clock-off, where no enables are issued. Any code outside the supported set holds both enables low and raises an invalid flag.

A registered ratio identifier gives the bus period in reference ticks. Downstream logic can use it to pick timing that depends on the ratio.

Top module: `clk_ratio_gen`

## Requirements
- R1: `ratio_o` reports the bus period in reference ticks for each ratio code: 0000→2 (1:1), 1100→3 (3:2), 0100→4 (2:1), 0110→5 (5:2), 1000→6 (3:1), 1110→7 (7:2), 1010→8 (4:1).
- R2: In every running mode, `core_en_o` is high in the first cycle after the first reference edge following reset release (cycle k=0), and then in every cycle with k even.
- R3: In every running mode, `bus_en_o` is high in each cycle where k is a multiple of `ratio_o`, and low in all other cycles.
- R4: For integer ratios, every bus enable coincides with a core enable. For half-integer ratios, only every second bus enable coincides with a core enable, starting with the first one; the others fall midway between two core enables.
- R5: Code 0011 (bypass) sets `bypass_o`=1 and `ratio_o`=2, and produces the same enables as 1:1. `bypass_o` is 0 for every other code.
- R6: Code 1111 (clock-off) sets `clk_off_o`=1 and `ratio_o`=0, and holds both enables low. `clk_off_o` is 0 for every other code.
- R7: Every other code not listed in R1, R5 or R6 sets `invalid_o`=1 and `ratio_o`=0, and holds both enables low. `invalid_o` is 0 for listed codes.
- R8: The code is sampled while reset is asserted. A change of `cfg_i` after release has no effect on any output until the next reset.
- R9: While reset is asserted, both enables are low. After one reference edge in reset, the status outputs reflect `cfg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the core rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 4 | Ratio configuration code |
| core_en_o | output | 1 | Core-cycle enable pulse |
| bus_en_o | output | 1 | Bus-cycle enable pulse |
| bypass_o | output | 1 | Bypass mode selected |
| clk_off_o | output | 1 | Clock-off mode selected |
| invalid_o | output | 1 | Unsupported code selected |
| ratio_o | output | 4 | Bus period in reference ticks, 0 when stopped |

## Verification
On every cycle, the assertions check four things: no enable is issued in clock-off or invalid mode, neither enable fires twice in a row, an integer ratio never issues a bus enable without a core enable, and the frozen mode stays stable once reset has ended.

Only the bench scenarios can show the rest. These are the exact code-to-period mapping, the position of the first pulse after release, the alternating alignment in half-integer modes, and the insensitivity to a code change in mid-run. The bench covers all sixteen codes.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int unsigned CFG_W    = 4;
  localparam int unsigned MAX_HALF = 8;
  localparam int unsigned HALF_W   = $clog2(MAX_HALF + 1);

  typedef struct packed {
    logic [HALF_W-1:0] half;   // bus period in reference ticks, 0 = stopped
    logic              bypass;
    logic              off;
    logic              bad;
  } mode_t;

  function automatic mode_t decode_cfg(input logic [CFG_W-1:0] c);
    mode_t m;
    m = '0;
    case (c)
      4'b0000: m.half = HALF_W'(2);
      4'b1100: m.half = HALF_W'(3);
      4'b0100: m.half = HALF_W'(4);
      4'b0110: m.half = HALF_W'(5);
      4'b1000: m.half = HALF_W'(6);
      4'b1110: m.half = HALF_W'(7);
      4'b1010: m.half = HALF_W'(8);
      4'b0011: begin m.half = HALF_W'(2); m.bypass = 1'b1; end
      4'b1111: m.off = 1'b1;
      default: m.bad = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ratio_cfg_latch.sv
module ratio_cfg_latch
  import ratio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output mode_t            mode_o,
  output logic             run_o
);
  logic  hold_q;
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b1;
    else         hold_q <= 1'b0;
  end

  // sample only in reset and on the first edge after release
  always_ff @(posedge clk_i) begin
    if (hold_q) mode_q <= decode_cfg(cfg_i);
  end

  assign mode_o = mode_q;
  assign run_o  = ~hold_q;

  // R8
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> $stable(mode_q));
endmodule

// File: rtl/ratio_phase_gen.sv
module ratio_phase_gen
  import ratio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              core_en_o,
  output logic              bus_en_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              ph_q;
  logic              active;
  logic              wrap;

  assign active = run_i && (half_i != '0);
  assign wrap   = (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (active) begin
      cnt_q <= wrap ? '0 : cnt_q + HALF_W'(1);
      ph_q  <= ~ph_q;
    end
  end

  assign core_en_o = active && !ph_q;
  assign bus_en_o  = active && (cnt_q == '0);

  // R2
  core_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_o |=> !core_en_o);
  // R3
  bus_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |=> !bus_en_o);
  // R4
  int_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o && !half_i[0]) |-> core_en_o);
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import ratio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       cfg_i,
  output logic             core_en_o,
  output logic             bus_en_o,
  output logic             bypass_o,
  output logic             clk_off_o,
  output logic             invalid_o,
  output logic [3:0]       ratio_o
);
  mode_t mode;
  logic  run;

  ratio_cfg_latch i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .mode_o (mode),
    .run_o  (run)
  );

  ratio_phase_gen i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .half_i    (mode.half),
    .core_en_o (core_en_o),
    .bus_en_o  (bus_en_o)
  );

  assign bypass_o  = mode.bypass;
  assign clk_off_o = mode.off;
  assign invalid_o = mode.bad;
  assign ratio_o   = 4'(mode.half);

  // R6 R7
  stopped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_off_o || invalid_o) |-> !(core_en_o || bus_en_o));
endmodule

// File: tb/test_clk_ratio_gen.sv
module test_clk_ratio_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] cfg_i;
  logic       core_en_o, bus_en_o, bypass_o, clk_off_o, invalid_o;
  logic [3:0] ratio_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  clk_ratio_gen i_clk_ratio_gen (.*);

  function automatic int exp_half(input logic [3:0] c);
    case (c)
      4'b0000: return 2;
      4'b1100: return 3;
      4'b0100: return 4;
      4'b0110: return 5;
      4'b1000: return 6;
      4'b1110: return 7;
      4'b1010: return 8;
      4'b0011: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_status(input logic [3:0] c, input string pre);
    int h;
    h = exp_half(c);
    chk({pre, (h == 0) ? ((c == 4'hF) ? " R6 ratio" : " R7 ratio") : " R1 ratio"},
        int'(ratio_o), h);
    chk({pre, " R5 bypass"}, int'(bypass_o), int'(c == 4'b0011));
    chk({pre, " R6 clk_off"}, int'(clk_off_o), int'(c == 4'b1111));
    chk({pre, " R7 invalid"}, int'(invalid_o), int'(h == 0 && c != 4'b1111));
  endtask

  task automatic run_code(input logic [3:0] c);
    int h;
    bit core_x, bus_x;
    h = exp_half(c);
    @(negedge clk_i);
    cfg_i  = c;
    rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R9 core in reset", int'(core_en_o), 0);
      chk("R9 bus in reset", int'(bus_en_o), 0);
      chk_status(c, "R9");
    end
    rst_ni = 1'b1;
    @(posedge clk_i);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      core_x = (h != 0) && (k % 2 == 0);
      bus_x  = (h != 0) && (k % h == 0);
      chk((h == 0) ? "R6/R7 core" : (k > 10 ? "R8 core" : "R2 core"),
          int'(core_en_o), int'(core_x));
      chk((h == 0) ? "R6/R7 bus" : (k > 10 ? "R8 bus" : "R3 bus"),
          int'(bus_en_o), int'(bus_x));
      if (bus_x) chk("R4 align", int'(core_en_o), int'(((k / h) % 2 == 0) || (h % 2 == 0)));
      if (k > 10) chk_status(c, "R8");
      else        chk_status(c, "run");
      if (k == 10) cfg_i = c ^ 4'b0110;
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    cfg_i  = 4'b0000;
    repeat (2) @(negedge clk_i);
    for (int c = 0; c < 16; c++) run_code(4'(c));
    run_code(4'b1100);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule